// File: doc/BRIEF.md
# Byte-Command Counter-Mode Register Front End

This block is the register-side front end of a counter-mode cipher unit. Commands arrive one byte at a time on an AXI4-Stream slave. Each command names a register and either reads or writes it, and read answers leave on an AXI4-Stream master. The block holds a control byte, a 16-byte key, a 12-byte nonce, a 16-byte input block and a 16-byte output block. Registers wider than a byte are reached one byte per command through a byte index that each register keeps for itself.

Writing the control register starts an external keystream engine. The block presents the key and a counter block made of the nonce and a 32-bit counter. It pulses a start signal, waits for the engine's done pulse, and then stores the input block XOR the returned keystream as the output block. The counter can be reloaded from the nonce, or it can continue from the previous block.

Top module: `ctr_cmd_frontend`

## Requirements
- R1: A command byte is decoded as bit 7 ignored, bits 6:4 the register address and bits 3:0 the command. Command 0x0 is a read and 0x1 is a write. Any other command code is consumed with no response and no state change, and the next byte is again taken as a command.
- R2: A write takes the following input byte as its payload. A read emits exactly one byte on the output stream. Addresses are 0 control, 1 key, 2 nonce, 3 data-in, 4 data-out. Addresses 5 to 7 read as 0x00 and ignore writes.
- R3: Key, data-in and data-out have 16 bytes and the nonce has 12. Each has its own byte index, which starts at 0, advances by one on every read or accepted write of that register, and wraps to 0 after the last byte. Byte index 0 is the most significant byte of the 128-bit key, block and keystream buses.
- R4: While a read response is waiting, s_tready is low. m_tvalid and m_tdata stay unchanged until m_tready is high.
- R5: Reading the control register returns bit 3 finished, bit 2 cipher start, bit 1 counter start, and zero in bits 7:4 and bit 0.
- R6: A control write with bits 2 and 1 set loads the counter with 1. In the next cycle eng_start pulses for one cycle while eng_block shows the nonce in bits 127:32 and the big-endian counter in bits 31:0.
- R7: A control write with bit 2 set and bit 1 clear launches with the counter left as it was. Each completed block adds 1 to the counter.
- R8: When eng_done arrives during a running operation, data-out becomes data-in XOR eng_keystream and the control register becomes 0x08.
- R9: A launch clears the finished flag. Any control write without bit 0 is ignored while an operation is running: no start pulse, and the counter is unchanged.
- R10: A control write with bit 0 set clears control, key, nonce, data-in, the counter and every byte index. Data-out keeps its contents. A done that arrives after this reset is ignored.
- R11: Writes to data-out are ignored and do not move its index. Control bit 3 cannot be written.
- R12: After the synchronous active-low reset, every register, index and the counter are zero, s_tready is high, and m_tvalid and eng_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 8 | Command and payload bytes |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted |
| m_tdata | output | 8 | Read response byte |
| m_tvalid | output | 1 | Response valid |
| m_tready | input | 1 | Response taken |
| eng_key | output | 128 | Key to the keystream engine |
| eng_block | output | 128 | Counter block: nonce then counter |
| eng_start | output | 1 | One-cycle engine start |
| eng_done | input | 1 | One-cycle engine completion |
| eng_keystream | input | 128 | Keystream, valid with eng_done |

## Verification
The hardest cases to reach are the ones inside the busy window. These are a second control write while the engine is still running, and a soft reset that lands before the engine's done pulse. The stub engine in the bench answers after a fixed latency of several command times. This lets the bench queue those writes in the middle of the operation. It then checks the start-pulse count, the counter value in the next captured block, and the unchanged data-out contents.

// File: rtl/ctrfe_pkg.sv
// Package: shared constants and types for the counter-mode register front end.
// Assumes byte-wide command streams and a 3-bit register address.
package ctrfe_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd1;
    localparam logic [ADDR_W-1:0] A_NONCE = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DOUT  = 3'd4;

    localparam logic [3:0] CMD_RD = 4'h0;
    localparam logic [3:0] CMD_WR = 4'h1;

    localparam logic [BYTE_W-1:0] CTRL_FINISHED = 8'h08;

    typedef enum logic [1:0] {
        P_CMD  = 2'd0,
        P_DATA = 2'd1,
        P_RESP = 2'd2
    } prs_state_t;
endpackage

// File: rtl/ctrfe_parser.sv
// Module: command parser. Decodes command bytes, collects write payloads and
// holds one read response on the output stream. Assumes rd_data is the
// addressed register's current byte, presented combinationally for acc_addr.
module ctrfe_parser
    import ctrfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [BYTE_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_data
);
    prs_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] resp_q;
    logic              resp_vld_q;
    logic              unused_rsvd;

    assign unused_rsvd = s_tdata[7];

    // Strobes and addressing for the register bank.
    always_comb begin
        s_tready = (state_q != P_RESP);
        rd_stb   = (state_q == P_CMD) && s_tvalid && (s_tdata[3:0] == CMD_RD);
        wr_stb   = (state_q == P_DATA) && s_tvalid;
        acc_addr = (state_q == P_DATA) ? addr_q : s_tdata[6:4];
        wr_data  = s_tdata;
    end

    assign m_tdata  = resp_q;
    assign m_tvalid = resp_vld_q;

    // Command sequencing: command byte, optional payload, held response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= P_CMD;
            addr_q     <= '0;
            resp_q     <= '0;
            resp_vld_q <= 1'b0;
        end else begin
            case (state_q)
                P_CMD: begin
                    if (s_tvalid) begin
                        if (s_tdata[3:0] == CMD_WR) begin
                            addr_q  <= s_tdata[6:4];
                            state_q <= P_DATA;
                        end else if (s_tdata[3:0] == CMD_RD) begin
                            resp_q     <= rd_data;
                            resp_vld_q <= 1'b1;
                            state_q    <= P_RESP;
                        end
                    end
                end
                P_DATA: begin
                    if (s_tvalid) state_q <= P_CMD;
                end
                P_RESP: begin
                    if (m_tready) begin
                        resp_vld_q <= 1'b0;
                        state_q    <= P_CMD;
                    end
                end
                default: state_q <= P_CMD;
            endcase
        end
    end

    // R4: no new byte is taken while a response is pending.
    assert_no_accept_in_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tready && m_tvalid));

    // R4: a stalled response holds its value.
    assert_resp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
endmodule

// File: rtl/ctrfe_bytefile.sv
// Module: byte-addressed register of DEPTH bytes with its own wrapping index.
// Reads and writes act on the byte at the index and then advance it. A whole
// block load and separate data/index clears are provided. Byte 0 maps to the
// most significant byte of the flat view.
module ctrfe_bytefile #(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_data,
    input  logic               clr_idx,
    input  logic               load,
    input  logic [DEPTH*8-1:0] load_val,
    input  logic               wr,
    input  logic               rd,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [DEPTH*8-1:0] flat
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;

    assign idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    assign rdata   = mem[idx_q];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flat
            assign flat[DEPTH*8-1-8*g -: 8] = mem[g];
        end
    endgenerate

    // Byte storage: clear, whole-block load, or single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_data) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= load_val[DEPTH*8-1-8*i -: 8];
        end else if (wr) begin
            mem[idx_q] <= wdata;
        end
    end

    // Byte index: advances on every access, wraps after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_idx) idx_q <= '0;
        else if (wr || rd)     idx_q <= idx_nxt;
    end

    // R3: an access at the last byte returns the index to byte 0.
    assert_idx_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr || rd) && !clr_idx && idx_q == LAST) |=> (idx_q == '0));
endmodule

// File: rtl/ctrfe_ctrl.sv
// Module: control register and block counter. Launches the keystream engine,
// reloads or continues the counter, and closes an operation on done.
// Assumes at most one control write per cycle and a one-cycle done pulse.
module ctrfe_ctrl #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       wdata,
    input  logic             eng_done,
    output logic [7:0]       ctrl_q,
    output logic [CTR_W-1:0] ctr_q,
    output logic             soft_clr,
    output logic             dout_load,
    output logic             eng_start
);
    logic running;
    logic accept;
    logic launch;
    logic unused_hi;

    assign unused_hi = ^{wdata[7:3]};

    // Decode of control writes and engine completion.
    always_comb begin
        running   = ctrl_q[2];
        soft_clr  = ctrl_wr && wdata[0];
        accept    = ctrl_wr && !wdata[0] && !running;
        launch    = accept && wdata[2];
        dout_load = eng_done && running && !soft_clr;
    end

    // Control bits, counter and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ctr_q     <= '0;
            eng_start <= 1'b0;
        end else begin
            eng_start <= launch;
            if (soft_clr) begin
                ctrl_q <= '0;
                ctr_q  <= '0;
            end else if (dout_load) begin
                ctrl_q <= 8'h08;
                ctr_q  <= ctr_q + 1'b1;
            end else if (accept) begin
                ctrl_q[2:1] <= wdata[2:1];
                if (launch) ctrl_q[3] <= 1'b0;
                if (launch && wdata[1]) ctr_q <= CTR_W'(1);
            end
        end
    end

    // R6: the start pulse lasts exactly one cycle.
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R9: a start is shown with the operation running and finished cleared.
    assert_start_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (ctrl_q[2] && !ctrl_q[3]));

    // R8: completion leaves only the finished flag set.
    assert_done_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_load |=> (ctrl_q == 8'h08));
endmodule

// File: rtl/ctr_cmd_frontend.sv
// Module: top of the byte-command counter-mode register front end. Connects
// the parser, the control unit and the four byte registers, and muxes reads.
// Assumes the keystream engine holds eng_keystream valid while eng_done is high.
module ctr_cmd_frontend
    import ctrfe_pkg::*;
#(
    parameter int KEY_BYTES   = 16,
    parameter int NONCE_BYTES = 12,
    parameter int BLK_BYTES   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             s_tdata,
    input  logic                   s_tvalid,
    output logic                   s_tready,
    output logic [7:0]             m_tdata,
    output logic                   m_tvalid,
    input  logic                   m_tready,
    output logic [KEY_BYTES*8-1:0] eng_key,
    output logic [BLK_BYTES*8-1:0] eng_block,
    output logic                   eng_start,
    input  logic                   eng_done,
    input  logic [BLK_BYTES*8-1:0] eng_keystream
);
    localparam int CTR_W = (BLK_BYTES - NONCE_BYTES) * 8;

    logic              rd_stb, wr_stb;
    logic [ADDR_W-1:0] acc_addr;
    logic [7:0]        wr_data, rd_data;
    logic [7:0]        ctrl_q;
    logic [CTR_W-1:0]  ctr_q;
    logic              soft_clr, dout_load;
    logic [7:0]        key_rd, nonce_rd, din_rd, dout_rd;
    logic [NONCE_BYTES*8-1:0] nonce_flat;
    logic [BLK_BYTES*8-1:0]   din_flat, dout_flat;
    logic              unused_dout;

    assign unused_dout = ^dout_flat;

    ctrfe_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .acc_addr(acc_addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    ctrfe_ctrl #(.CTR_W(CTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_stb && acc_addr == A_CTRL), .wdata(wr_data),
        .eng_done(eng_done), .ctrl_q(ctrl_q), .ctr_q(ctr_q),
        .soft_clr(soft_clr), .dout_load(dout_load), .eng_start(eng_start)
    );

    ctrfe_bytefile #(.DEPTH(KEY_BYTES)) u_key (
        .clk(clk), .rst_n(rst_n), .clr_data(soft_clr), .clr_idx(soft_clr),
        .load(1'b0), .load_val('0),
        .wr(wr_stb && acc_addr == A_KEY), .rd(rd_stb && acc_addr == A_KEY),
        .wdata(wr_data), .rdata(key_rd), .flat(eng_key)
    );

    ctrfe_bytefile #(.DEPTH(NONCE_BYTES)) u_nonce (
        .clk(clk), .rst_n(rst_n), .clr_data(soft_clr), .clr_idx(soft_clr),
        .load(1'b0), .load_val('0),
        .wr(wr_stb && acc_addr == A_NONCE), .rd(rd_stb && acc_addr == A_NONCE),
        .wdata(wr_data), .rdata(nonce_rd), .flat(nonce_flat)
    );

    ctrfe_bytefile #(.DEPTH(BLK_BYTES)) u_din (
        .clk(clk), .rst_n(rst_n), .clr_data(soft_clr), .clr_idx(soft_clr),
        .load(1'b0), .load_val('0),
        .wr(wr_stb && acc_addr == A_DIN), .rd(rd_stb && acc_addr == A_DIN),
        .wdata(wr_data), .rdata(din_rd), .flat(din_flat)
    );

    // Data-out: loaded only by completion; bus writes are dropped.
    ctrfe_bytefile #(.DEPTH(BLK_BYTES)) u_dout (
        .clk(clk), .rst_n(rst_n), .clr_data(1'b0), .clr_idx(soft_clr),
        .load(dout_load), .load_val(din_flat ^ eng_keystream),
        .wr(1'b0), .rd(rd_stb && acc_addr == A_DOUT),
        .wdata(wr_data), .rdata(dout_rd), .flat(dout_flat)
    );

    assign eng_block = {nonce_flat, ctr_q};

    // Read data select for the addressed register.
    always_comb begin
        case (acc_addr)
            A_CTRL:  rd_data = ctrl_q;
            A_KEY:   rd_data = key_rd;
            A_NONCE: rd_data = nonce_rd;
            A_DIN:   rd_data = din_rd;
            A_DOUT:  rd_data = dout_rd;
            default: rd_data = 8'h00;
        endcase
    end

    // R10: a soft reset empties key, counter block and control.
    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (eng_key == '0 && eng_block == '0 && ctrl_q == 8'h00));
endmodule

// File: tb/test_ctr_cmd_frontend.sv
module test_ctr_cmd_frontend;
    localparam int LAT = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   s_tdata = '0;
    logic         s_tvalid = 1'b0;
    logic         s_tready;
    logic [7:0]   m_tdata;
    logic         m_tvalid;
    logic         m_tready = 1'b0;
    logic [127:0] eng_key, eng_block, eng_keystream;
    logic         eng_start;
    logic         eng_done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ctr_cmd_frontend i_ctr_cmd_frontend (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .eng_key(eng_key), .eng_block(eng_block), .eng_start(eng_start),
        .eng_done(eng_done), .eng_keystream(eng_keystream)
    );

    // Behavioural engine stub: keystream = key ^ block ^ 0x3C.., done after LAT cycles.
    logic [127:0] cap_blk, ks_q;
    int lat_q, starts;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0; lat_q <= 0; starts <= 0; cap_blk <= '0; ks_q <= '0;
        end else begin
            eng_done <= 1'b0;
            if (eng_start) begin
                cap_blk <= eng_block;
                ks_q    <= eng_key ^ eng_block ^ {16{8'h3C}};
                lat_q   <= LAT;
                starts  <= starts + 1;
            end else if (lat_q > 0) begin
                lat_q <= lat_q - 1;
                if (lat_q == 1) eng_done <= 1'b1;
            end
        end
    end
    assign eng_keystream = ks_q;

    logic [7:0] key_m [16];
    logic [7:0] nonce_m [12];
    logic [7:0] din_m [16];
    logic [7:0] dout_m [16];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        s_tdata = b; s_tvalid = 1'b1;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        send({1'b0, a, 4'h1});
        send(d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        send({1'b0, a, 4'h0});
        while (!m_tvalid) @(negedge clk);
        v = m_tdata;
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    function automatic logic [127:0] exp_block(input logic [31:0] c);
        logic [127:0] b;
        for (int i = 0; i < 12; i++) b[127-8*i -: 8] = nonce_m[i];
        b[31:0] = c;
        return b;
    endfunction

    function automatic logic [7:0] exp_out(input int i, input logic [31:0] c);
        logic [127:0] b;
        b = exp_block(c);
        return din_m[i] ^ key_m[i] ^ b[127-8*i -: 8] ^ 8'h3C;
    endfunction

    task automatic check_dout(input logic [31:0] c, input string req);
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(3'd4, v);
            dout_m[i] = exp_out(i, c);
            chk(v == dout_m[i], req, v, dout_m[i]);
        end
    endtask

    task automatic launch_and_check(input logic [7:0] cw, input logic [31:0] c, input string req);
        int s0;
        logic [7:0] v;
        s0 = starts;
        wr(3'd0, cw);
        repeat (2) @(negedge clk);
        chk(starts == s0 + 1, req, starts, s0 + 1);
        chk(cap_blk == exp_block(c), req, cap_blk, exp_block(c));
        repeat (LAT + 4) @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h08, "R8", v, 8'h08);
        check_dout(c, "R8");
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(s_tready && !m_tvalid && !eng_start, "R12", {s_tready, m_tvalid, eng_start}, 3'b100);
        chk(eng_key == '0 && eng_block == '0, "R12", eng_key | eng_block, 0);
        rd(3'd0, v);
        chk(v == 8'h00, "R12", v, 0);
    endtask

    task automatic t_key();
        logic [7:0] v;
        logic [127:0] k;
        for (int i = 0; i < 16; i++) begin
            key_m[i] = 8'(8'h11 + i * 37);
            wr(3'd1, key_m[i]);
        end
        for (int i = 0; i < 16; i++) k[127-8*i -: 8] = key_m[i];
        chk(eng_key == k, "R3", eng_key, k);
        for (int i = 0; i < 16; i++) begin
            rd(3'd1, v);
            chk(v == key_m[i], "R2", v, key_m[i]);
        end
        rd(3'd1, v);
        chk(v == key_m[0], "R3", v, key_m[0]);
    endtask

    task automatic t_nonce_din();
        logic [7:0] v;
        for (int i = 0; i < 12; i++) begin
            nonce_m[i] = 8'(8'hA0 + i * 5);
            wr(3'd2, nonce_m[i]);
        end
        for (int i = 0; i < 12; i++) begin
            rd(3'd2, v);
            chk(v == nonce_m[i], "R3", v, nonce_m[i]);
        end
        for (int i = 0; i < 16; i++) begin
            din_m[i] = 8'(i * 17 + 3);
            wr(3'd3, din_m[i]);
        end
        rd(3'd3, v);
        chk(v == din_m[0], "R3", v, din_m[0]);
        for (int i = 1; i < 16; i++) rd(3'd3, v);
    endtask

    task automatic t_start();
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr(3'd0, 8'h06);
        repeat (2) @(negedge clk);
        chk(starts == s0 + 1, "R6", starts, s0 + 1);
        chk(cap_blk == exp_block(32'd1), "R6", cap_blk, exp_block(32'd1));
        rd(3'd0, v);
        chk(v == 8'h06, "R5", v, 8'h06);
        repeat (LAT + 4) @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h08, "R8", v, 8'h08);
        check_dout(32'd1, "R8");
    endtask

    task automatic t_continue();
        launch_and_check(8'h04, 32'd2, "R7");
    endtask

    task automatic t_busy();
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr(3'd0, 8'h04);
        rd(3'd0, v);
        chk(v == 8'h04, "R9", v, 8'h04);
        wr(3'd0, 8'h06);
        repeat (LAT + 4) @(negedge clk);
        chk(starts == s0 + 1, "R9", starts, s0 + 1);
        check_dout(32'd3, "R9");
        launch_and_check(8'h04, 32'd4, "R9");
    endtask

    task automatic t_cmds();
        logic [7:0] v;
        send(8'h12);
        repeat (3) @(negedge clk);
        chk(!m_tvalid, "R1", m_tvalid, 0);
        rd(3'd0, v);
        chk(v == 8'h08, "R1", v, 8'h08);
        send(8'h80);
        while (!m_tvalid) @(negedge clk);
        v = m_tdata;
        m_tready = 1'b1; @(negedge clk); m_tready = 1'b0;
        chk(v == 8'h08, "R1", v, 8'h08);
        wr(3'd6, 8'h5A);
        rd(3'd6, v);
        chk(v == 8'h00, "R2", v, 0);
        rd(3'd5, v);
        chk(v == 8'h00, "R2", v, 0);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        int s0;
        wr(3'd4, 8'hFF);
        rd(3'd4, v);
        chk(v == dout_m[0], "R11", v, dout_m[0]);
        for (int i = 1; i < 16; i++) rd(3'd4, v);
        s0 = starts;
        wr(3'd0, 8'h00);
        rd(3'd0, v);
        chk(v == 8'h08 && starts == s0, "R11", v, 8'h08);
    endtask

    task automatic t_backpressure();
        logic [7:0] v0;
        logic [7:0] v;
        send(8'h00);
        while (!m_tvalid) @(negedge clk);
        v0 = m_tdata;
        s_tdata = 8'h00; s_tvalid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!s_tready && m_tvalid && m_tdata == v0, "R4", {s_tready, m_tvalid, m_tdata}, {2'b01, v0});
        end
        m_tready = 1'b1; @(negedge clk); m_tready = 1'b0;
        @(negedge clk);
        s_tvalid = 1'b0;
        while (!m_tvalid) @(negedge clk);
        v = m_tdata;
        m_tready = 1'b1; @(negedge clk); m_tready = 1'b0;
        chk(v0 == 8'h08 && v == 8'h08, "R4", {v0, v}, 16'h0808);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        wr(3'd0, 8'h04);
        wr(3'd0, 8'h01);
        repeat (LAT + 6) @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h00, "R10", v, 0);
        chk(eng_key == '0 && eng_block == '0, "R10", eng_key | eng_block, 0);
        rd(3'd1, v);
        chk(v == 8'h00, "R10", v, 0);
        for (int i = 0; i < 16; i++) begin
            rd(3'd4, v);
            chk(v == dout_m[i], "R10", v, dout_m[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key();
        t_nonce_din();
        t_start();
        t_continue();
        t_busy();
        t_cmds();
        t_ignored();
        t_backpressure();
        t_soft_reset();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule